// File: doc/BRIEF.md
# Translation-Driven Permission Insertion Unit

This unit sits beside the address translation path of an untrusted accelerator and grows a per-accelerator permission table as translations are handed out. Each completed translation delivers a physical page number, the read and write rights the page table granted, and a flag marking a 2MB page. The unit looks the page up in an external permission cache, ORs the granted rights into the stored pair and, when that changes anything, writes the whole table block back to memory. A translation for a page at or beyond the bounds value is dropped and reported on an error pulse. The unit only ever raises rights. Lowering them is the job of a separate sequencer.

The table is flat. One block holds 512 pages as bit pairs and is 1024 bits (128 bytes) wide. One cache entry holds exactly one block, so a 2MB translation fills one whole entry. The translation input is valid/ready. `xl_ready` is high only while the unit is idle, so a new event waits until the previous one has been written through. Memory requests are valid/ready and must be held steady until accepted. Memory read responses arrive on a valid strobe and cannot be stalled. The cache answers every lookup exactly one cycle later. A permission check path shares the cache port and is granted only when the insertion side leaves the port free.

Top module: `perm_insert_unit`

## Requirements
- R1: After reset `xl_ready` is 1 and `xl_err`, `cp_lk_valid`, `cp_wr_valid` and `mem_req_valid` are 0.
- R2: A translation is taken on a cycle with `xl_valid` and `xl_ready` both high. For an in-bounds page, `xl_ready` is 0 from the next cycle until the event has finished.
- R3: If `xl_ppn >= xl_bound`, the event is taken without any cache or memory access, and `xl_err` is 1 for exactly the following cycle.
- R4: An in-bounds translation issues a cache lookup in its acceptance cycle. The lookup index is `xl_ppn >> 9`.
- R5: On a cache hit where the entry already holds every granted bit, no cache write and no memory access take place.
- R6: On a hit that lacks some granted bit, the merged block is written to the cache and exactly one memory write of that block follows. No memory read takes place.
- R7: On a miss, exactly one memory read of the block is made. The fetched block ORed with the new bits is then written to the cache and written back to memory once.
- R8: Within a block, page offset o (`xl_ppn[8:0]`) owns bit 2o (read) and bit 2o+1 (write). Only granted bits of the addressed page are set, and a bit that was already set is never cleared.
- R9: With `xl_huge` set, the granted bits are set for all 512 pages of the block, and `xl_ppn[8:0]` is ignored.
- R10: Each memory request addresses `tbl_base + index*128`.
- R11: `chk_gnt` is 1 only when `chk_req` is 1, the unit is idle and no translation is offered. A granted cycle carries no cache access from the unit.
- R12: A memory request that is not accepted keeps its valid, direction and address in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base | input | AW | Byte address of the permission table |
| xl_bound | input | PPN_W | First page number outside the table |
| xl_valid | input | 1 | Translation event offered |
| xl_ready | output | 1 | Translation event can be taken |
| xl_ppn | input | PPN_W | Translated physical page number |
| xl_rd | input | 1 | Read right granted |
| xl_wr | input | 1 | Write right granted |
| xl_huge | input | 1 | Translation is a 2MB page |
| xl_err | output | 1 | Out-of-bounds translation dropped |
| chk_req | input | 1 | Check path asks for the cache port |
| chk_gnt | output | 1 | Check path may use the cache port |
| cp_lk_valid | output | 1 | Cache lookup request |
| cp_lk_idx | output | PPN_W-9 | Cache lookup block index |
| cp_rsp_valid | input | 1 | Cache lookup response |
| cp_rsp_hit | input | 1 | Lookup hit |
| cp_rsp_data | input | 1024 | Cached block |
| cp_wr_valid | output | 1 | Cache write or allocate |
| cp_wr_idx | output | PPN_W-9 | Cache write block index |
| cp_wr_data | output | 1024 | Cache write block |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | AW | Block byte address |
| mem_req_wdata | output | 1024 | Write block |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 1024 | Read block |

## Verification
A wrong merge or a wrong latched event shows up in the block written to memory and to the cache in the same event. It can be seen as soon as `xl_ready` rises again, by comparing both copies with a model table. A wrong decision between hit and miss shows up as an extra or missing memory read or write in that event. A stuck or lost state shows up as `xl_ready` staying low, or returning at once after an in-bounds event. A wrong bounds compare shows up one cycle after acceptance, on `xl_err` and in the cache traffic of that cycle.

// File: rtl/pin_pkg.sv
package pin_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESP,
    ST_MRD,
    ST_MRSP,
    ST_MWR
  } pin_state_e;
endpackage

// File: rtl/pin_mask_gen.sv
module pin_mask_gen #(
  parameter int PAGES = 512,
  localparam int OFF_W = $clog2(PAGES)
) (
  input  logic [OFF_W-1:0]   off,
  input  logic               rd,
  input  logic               wr,
  input  logic               huge,
  output logic [2*PAGES-1:0] mask
);
  for (genvar g = 0; g < PAGES; g++) begin : g_pair
    logic sel;
    assign sel           = huge | (off == OFF_W'(g));
    assign mask[2*g]     = rd & sel;
    assign mask[2*g + 1] = wr & sel;
  end
endmodule

// File: rtl/pin_addr_calc.sv
module pin_addr_calc #(
  parameter int PPN_W = 24,
  parameter int OFF_W = 9,
  parameter int AW = 40,
  parameter int BLK_SH = 7,
  localparam int IDX_W = PPN_W - OFF_W
) (
  input  logic [PPN_W-1:0] ppn,
  input  logic [PPN_W-1:0] bound,
  input  logic [AW-1:0]    base,
  output logic             oob,
  output logic [IDX_W-1:0] idx,
  output logic [AW-1:0]    addr
);
  assign oob  = (ppn >= bound);
  assign idx  = ppn[PPN_W-1:OFF_W];
  assign addr = base + (AW'(idx) << BLK_SH);
endmodule

// File: rtl/pin_merge.sv
module pin_merge #(
  parameter int BLK_W = 1024
) (
  input  logic [BLK_W-1:0] old_blk,
  input  logic [BLK_W-1:0] add_bits,
  output logic [BLK_W-1:0] new_blk,
  output logic             grow
);
  assign new_blk = old_blk | add_bits;
  assign grow    = |(add_bits & ~old_blk);
endmodule

// File: rtl/perm_insert_unit.sv
module perm_insert_unit
  import pin_pkg::*;
#(
  parameter int PPN_W = 24,
  parameter int PAGES = 512,
  parameter int AW = 40,
  localparam int OFF_W = $clog2(PAGES),
  localparam int IDX_W = PPN_W - OFF_W,
  localparam int BLK_W = 2 * PAGES,
  localparam int BLK_SH = $clog2(BLK_W / 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    tbl_base,
  input  logic [PPN_W-1:0] xl_bound,
  input  logic             xl_valid,
  output logic             xl_ready,
  input  logic [PPN_W-1:0] xl_ppn,
  input  logic             xl_rd,
  input  logic             xl_wr,
  input  logic             xl_huge,
  output logic             xl_err,
  input  logic             chk_req,
  output logic             chk_gnt,
  output logic             cp_lk_valid,
  output logic [IDX_W-1:0] cp_lk_idx,
  input  logic             cp_rsp_valid,
  input  logic             cp_rsp_hit,
  input  logic [BLK_W-1:0] cp_rsp_data,
  output logic             cp_wr_valid,
  output logic [IDX_W-1:0] cp_wr_idx,
  output logic [BLK_W-1:0] cp_wr_data,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [AW-1:0]    mem_req_addr,
  output logic [BLK_W-1:0] mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [BLK_W-1:0] mem_rsp_rdata
);
  pin_state_e       state;
  logic             in_oob;
  logic [IDX_W-1:0] in_idx;
  logic [AW-1:0]    in_addr;
  logic [BLK_W-1:0] in_mask;
  logic [IDX_W-1:0] ev_idx;
  logic [AW-1:0]    ev_addr;
  logic [BLK_W-1:0] ev_mask;
  logic [BLK_W-1:0] merged_q;
  logic [BLK_W-1:0] merge_in;
  logic [BLK_W-1:0] merge_out;
  logic             merge_grow;
  logic             err_q;
  logic             take;

  pin_addr_calc #(
    .PPN_W(PPN_W), .OFF_W(OFF_W), .AW(AW), .BLK_SH(BLK_SH)
  ) u_addr (
    .ppn(xl_ppn), .bound(xl_bound), .base(tbl_base),
    .oob(in_oob), .idx(in_idx), .addr(in_addr)
  );

  pin_mask_gen #(.PAGES(PAGES)) u_mask (
    .off(xl_ppn[OFF_W-1:0]), .rd(xl_rd), .wr(xl_wr), .huge(xl_huge),
    .mask(in_mask)
  );

  assign merge_in = (state == ST_MRSP) ? mem_rsp_rdata : cp_rsp_data;

  pin_merge #(.BLK_W(BLK_W)) u_merge (
    .old_blk(merge_in), .add_bits(ev_mask),
    .new_blk(merge_out), .grow(merge_grow)
  );

  assign xl_ready    = (state == ST_IDLE);
  assign take        = xl_valid & xl_ready;
  assign chk_gnt     = chk_req & (state == ST_IDLE) & ~xl_valid;
  assign cp_lk_valid = take & ~in_oob;
  assign cp_lk_idx   = in_idx;
  assign xl_err      = err_q;

  always_comb begin
    cp_wr_valid = 1'b0;
    if (state == ST_RESP && cp_rsp_valid && cp_rsp_hit && merge_grow) cp_wr_valid = 1'b1;
    if (state == ST_MRSP && mem_rsp_valid) cp_wr_valid = 1'b1;
  end
  assign cp_wr_idx  = ev_idx;
  assign cp_wr_data = merge_out;

  assign mem_req_valid = (state == ST_MRD) || (state == ST_MWR);
  assign mem_req_write = (state == ST_MWR);
  assign mem_req_addr  = ev_addr;
  assign mem_req_wdata = merged_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      err_q    <= 1'b0;
      ev_idx   <= '0;
      ev_addr  <= '0;
      ev_mask  <= '0;
      merged_q <= '0;
    end else begin
      err_q <= take & in_oob;
      unique case (state)
        ST_IDLE: begin
          if (take && !in_oob) begin
            ev_idx  <= in_idx;
            ev_addr <= in_addr;
            ev_mask <= in_mask;
            state   <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (cp_rsp_valid) begin
            if (!cp_rsp_hit) begin
              state <= ST_MRD;
            end else if (merge_grow) begin
              merged_q <= merge_out;
              state    <= ST_MWR;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_MRD: begin
          if (mem_req_ready) state <= ST_MRSP;
        end
        ST_MRSP: begin
          if (mem_rsp_valid) begin
            merged_q <= merge_out;
            state    <= ST_MWR;
          end
        end
        ST_MWR: begin
          if (mem_req_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pin_checker.sv
module pin_checker #(
  parameter int PPN_W = 24,
  parameter int PAGES = 512,
  parameter int AW = 40,
  localparam int OFF_W = $clog2(PAGES),
  localparam int IDX_W = PPN_W - OFF_W,
  localparam int BLK_W = 2 * PAGES,
  localparam int BLK_SH = $clog2(BLK_W / 8)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    tbl_base,
  input logic [PPN_W-1:0] xl_bound,
  input logic             xl_valid,
  input logic             xl_ready,
  input logic [PPN_W-1:0] xl_ppn,
  input logic             xl_err,
  input logic             chk_gnt,
  input logic             cp_lk_valid,
  input logic [IDX_W-1:0] cp_lk_idx,
  input logic             cp_rsp_valid,
  input logic [BLK_W-1:0] cp_rsp_data,
  input logic             cp_wr_valid,
  input logic [BLK_W-1:0] cp_wr_data,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_write,
  input logic [AW-1:0]    mem_req_addr
);
  logic [AW-1:0] rel_addr;
  assign rel_addr = mem_req_addr - tbl_base;

  assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && xl_ready && xl_ppn < xl_bound) |=> !xl_ready);

  assert_oob_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && xl_ready && xl_ppn >= xl_bound) |-> !cp_lk_valid);

  assert_oob_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && xl_ready && xl_ppn >= xl_bound) |=> (xl_err && xl_ready));

  assert_lookup_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && xl_ready && xl_ppn < xl_bound) |-> (cp_lk_valid && cp_lk_idx == xl_ppn[PPN_W-1:OFF_W]));

  assert_no_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_wr_valid && cp_rsp_valid) |-> ((cp_wr_data & cp_rsp_data) == cp_rsp_data));

  assert_block_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (rel_addr[BLK_SH-1:0] == '0));

  assert_port_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    chk_gnt |-> (!cp_lk_valid && !cp_wr_valid));

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));
endmodule

bind perm_insert_unit pin_checker #(.PPN_W(PPN_W), .PAGES(PAGES), .AW(AW)) u_pin_checker (.*);

// File: tb/perm_insert_unit_tb.sv
`timescale 1ns/1ps
module perm_insert_unit_tb;
  localparam int PPN_W = 24;
  localparam int PAGES = 512;
  localparam int AW = 40;
  localparam int IDX_W = PPN_W - 9;
  localparam int BLK_W = 1024;
  localparam int NENT = 8;
  localparam logic [AW-1:0] BASE = 40'h0000_4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] tbl_base = BASE;
  logic [PPN_W-1:0] xl_bound = PPN_W'(NENT * PAGES);
  logic xl_valid = 1'b0, xl_rd = 1'b0, xl_wr = 1'b0, xl_huge = 1'b0;
  logic [PPN_W-1:0] xl_ppn = '0;
  logic xl_ready, xl_err, chk_gnt;
  logic chk_req = 1'b0;
  logic cp_lk_valid, cp_wr_valid;
  logic [IDX_W-1:0] cp_lk_idx, cp_wr_idx;
  logic cp_rsp_valid = 1'b0, cp_rsp_hit = 1'b0;
  logic [BLK_W-1:0] cp_rsp_data = '0, cp_wr_data;
  logic mem_req_valid, mem_req_write;
  logic mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic [BLK_W-1:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [BLK_W-1:0] mem_rsp_rdata = '0;

  perm_insert_unit u_dut (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic             cv [NENT];
  logic [BLK_W-1:0] cd [NENT];
  logic [BLK_W-1:0] md [NENT];
  logic [BLK_W-1:0] exp_t [NENT];
  int wr_cnt = 0, rd_cnt = 0, addr_bad = 0, lk_cnt = 0, cw_cnt = 0;
  int dly = 0, pidx = 0;

  always @(posedge clk) begin
    cp_rsp_valid <= cp_lk_valid;
    if (cp_lk_valid) begin
      lk_cnt <= lk_cnt + 1;
      cp_rsp_hit  <= cv[cp_lk_idx[2:0]];
      cp_rsp_data <= cd[cp_lk_idx[2:0]];
    end
    if (cp_wr_valid) begin
      cw_cnt <= cw_cnt + 1;
      cv[cp_wr_idx[2:0]] <= 1'b1;
      cd[cp_wr_idx[2:0]] <= cp_wr_data;
    end
  end

  always @(posedge clk) begin
    logic [AW-1:0] rel;
    mem_req_ready <= ($urandom % 3) != 0;
    mem_rsp_valid <= 1'b0;
    if (dly == 1) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_rdata <= md[pidx];
    end
    if (dly != 0) dly <= dly - 1;
    if (mem_req_valid && mem_req_ready) begin
      rel = mem_req_addr - BASE;
      if (rel[6:0] != 0 || (rel >> 7) >= NENT) addr_bad <= addr_bad + 1;
      if (mem_req_write) begin
        wr_cnt <= wr_cnt + 1;
        md[rel[9:7]] <= mem_req_wdata;
      end else begin
        rd_cnt <= rd_cnt + 1;
        dly  <= 2;
        pidx <= int'(rel[9:7]);
      end
    end
  end

  function automatic logic [BLK_W-1:0] bits_for(input int off, input bit r, input bit w, input bit h);
    logic [BLK_W-1:0] m = '0;
    for (int p = 0; p < PAGES; p++) begin
      if (h || p == off) begin
        m[2*p]   = r;
        m[2*p+1] = w;
      end
    end
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_blk(input string req, input int e, input logic [BLK_W-1:0] act, input logic [BLK_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s entry %0d actual %h expected %h", req, e, act, exp);
    end
  endtask

  task automatic run_event(input int ppn, input bit r, input bit w, input bit h, input bit probe_gnt);
    int e = (ppn >> 9) % NENT;
    bit oob = (ppn >= int'(xl_bound));
    bit hit = cv[e];
    logic [BLK_W-1:0] nb = exp_t[e] | bits_for(ppn % PAGES, r, w, h);
    int w0 = wr_cnt, r0 = rd_cnt, l0 = lk_cnt, c0 = cw_cnt;
    int exp_w, exp_r;
    @(negedge clk);
    xl_ppn = PPN_W'(ppn); xl_rd = r; xl_wr = w; xl_huge = h; xl_valid = 1'b1;
    while (!xl_ready) @(negedge clk);
    @(negedge clk);
    xl_valid = 1'b0;
    if (oob) begin
      check(xl_err == 1'b1, "R3 err pulse", xl_err, 1);
      check(lk_cnt == l0, "R3 no lookup", lk_cnt - l0, 0);
      @(negedge clk);
      check(xl_err == 1'b0, "R3 err one cycle", xl_err, 0);
      check(wr_cnt == w0 && rd_cnt == r0, "R3 no memory", wr_cnt - w0 + rd_cnt - r0, 0);
      return;
    end
    check(xl_ready == 1'b0, "R2 busy after take", xl_ready, 0);
    check(lk_cnt == l0 + 1, "R4 one lookup", lk_cnt - l0, 1);
    while (!xl_ready) begin
      if (probe_gnt) begin
        chk_req = 1'b1;
        #1 check(chk_gnt == 1'b0, "R11 no grant while busy", chk_gnt, 0);
      end
      @(negedge clk);
    end
    chk_req = 1'b0;
    exp_r = hit ? 0 : 1;
    exp_w = (!hit || nb != exp_t[e]) ? 1 : 0;
    check(rd_cnt - r0 == exp_r, hit ? "R6 no read on hit" : "R7 one read on miss", rd_cnt - r0, exp_r);
    check(wr_cnt - w0 == exp_w, hit ? (exp_w != 0 ? "R6 one write" : "R5 no write") : "R7 write back",
          wr_cnt - w0, exp_w);
    check(cw_cnt - c0 == exp_w, "R5/R6/R7 cache writes", cw_cnt - c0, exp_w);
    check(addr_bad == 0, "R10 address", addr_bad, 0);
    exp_t[e] = nb;
    check_blk(h ? "R9 table block" : "R8 table block", e, md[e], nb);
    check(cv[e] == 1'b1, "R7 entry valid", cv[e], 1);
    check_blk("R8 cache block", e, cd[e], nb);
  endtask

  initial begin
    int s;
    s = $urandom(32'd1234);
    for (int k = 0; k < NENT; k++) begin
      md[k] = (k % 2 == 0) ? ({32{$urandom}} & {32{$urandom}} & {32{$urandom}}) : '0;
      exp_t[k] = md[k];
      cv[k] = (k < 2);
      cd[k] = md[k];
    end
    repeat (3) @(negedge clk);
    check(xl_ready == 1'b1, "R1 ready", xl_ready, 1);
    check(cp_lk_valid == 1'b0 && cp_wr_valid == 1'b0, "R1 cache idle", cp_lk_valid, 0);
    check(mem_req_valid == 1'b0 && xl_err == 1'b0, "R1 mem idle", mem_req_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_req = 1'b1;
    #1 check(chk_gnt == 1'b1, "R11 grant when idle", chk_gnt, 1);
    xl_valid = 1'b1; xl_ppn = PPN_W'(5000);
    #1 check(chk_gnt == 1'b0, "R11 translation first", chk_gnt, 0);
    xl_valid = 1'b0; chk_req = 1'b0;
    run_event(3, 1, 0, 0, 1);
    run_event(3, 1, 0, 0, 0);
    run_event(3, 0, 1, 0, 0);
    run_event(3, 1, 0, 0, 0);
    run_event(2 * PAGES + 511, 1, 1, 0, 1);
    run_event(3 * PAGES, 0, 1, 1, 0);
    run_event(3 * PAGES + 7, 1, 0, 1, 0);
    run_event(4 * PAGES, 0, 0, 0, 0);
    run_event(NENT * PAGES, 1, 1, 0, 0);
    xl_bound = PPN_W'(4000);
    run_event(4000, 1, 0, 0, 0);
    run_event(3999, 0, 1, 0, 0);
    xl_bound = PPN_W'(NENT * PAGES);
    for (int i = 0; i < 150; i++) begin
      if ($urandom % 8 == 0) cv[$urandom % NENT] = 1'b0;
      if ($urandom % 8 == 0) cd[0] = cd[0];
      run_event(int'($urandom % (NENT * PAGES)), bit'($urandom), bit'($urandom),
                ($urandom % 10) == 0, ($urandom % 4) == 0);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule